// File: doc/BRIEF.md
# Programmable-Level Interrupt Request Controller

This block collects twelve level-sensitive interrupt request lines from peripheral resources and tells the CPU which one needs service. Each line has a 2-bit priority code. Software writes these codes into three byte-wide, write-only priority registers on a simple register write bus. Each code selects level 1, level 2 or "disabled". The block registers the request lines, picks the most urgent pending request that is enabled, and drives three registered results to the CPU:

- a pending flag,
- the required level of the winning request,
- the upper-byte and lower-byte addresses of that request's vector table entry.

The CPU supplies its current interrupt mask level. The pending flag asserts only when the winning level is numerically below that mask.

The block sits between the peripherals and the CPU's interrupt entry logic. The CPU uses the level to decide acceptance. It uses the two addresses to fetch the service routine's entry point. Stacking, vector fetch and acknowledge sequencing stay inside the CPU.

Top module: `irq_lvl_ctrl`

## Requirements
- R1: After reset every priority register holds 0xFF. All twelve sources are therefore disabled. With every request line high, `irq_pend` is 0 and `irq_lvl` is 3.
- R2: The priority register at address 0x007C holds the codes of sources 0 to 3, at 0x007D sources 4 to 7, and at 0x007E sources 8 to 11. Inside each register, the source with the lowest number uses bits 1:0, the next uses bits 3:2, then bits 5:4, then bits 7:6.
- R3: The code of a source decodes as follows:
  - code 00 means level 1,
  - code 01 means level 1,
  - code 10 means level 2,
  - code 11 means the source is disabled and takes no part in arbitration.
  - `irq_lvl` never reads 0.
- R4: Among raised, enabled requests, the lowest numeric level wins.
- R5: When two or more winning candidates have the same level, the lowest source number wins.
- R6: `irq_pend` is 1 only when a winner exists and its level is numerically below `mask_lvl`. A change of `mask_lvl` shows on `irq_pend` after one clock edge.
- R7: For winning source n, `vec_hi_addr` equals 0xFFFA − 2n and `vec_lo_addr` equals 0xFFFB − 2n.
- R8: A write to any 16-bit address other than 0x007C, 0x007D or 0x007E changes no priority code.
- R9: A change on the request lines shows on the outputs after exactly two rising clock edges: one edge for input registration and one for the output register.
- R10: When no raised request is enabled, the outputs are:
  - `irq_lvl` = 3,
  - `irq_pend` = 0,
  - `vec_hi_addr` = 0x0000,
  - `vec_lo_addr` = 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_req | input | 12 | Request lines; bit n belongs to source n |
| mask_lvl | input | 2 | CPU's current interrupt mask level |
| irq_pend | output | 1 | Interrupt pending towards the CPU |
| irq_lvl | output | 2 | Level of the winning request; 3 when there is none |
| vec_hi_addr | output | 16 | Address of the vector entry's upper byte |
| vec_lo_addr | output | 16 | Address of the vector entry's lower byte |

## Verification
The hardest situation to reach from the ports is a tie among requests whose codes differ but decode to the same level. Codes 00 and 01 both mean level 1, so such a tie depends on decoding and priority working together. The stimulus programs one source with code 00 and a higher-numbered source with code 01, then raises both lines at once. It then repeats the pattern at level 2 with a lower-level rival absent, so that ordering by source number is the only thing left to decide the winner. Every one of the twelve vector addresses is reached by enabling all sources and raising a single line at a time.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    parameter int unsigned IRQ_SRC_N   = 12;
    parameter int unsigned IRQ_CODE_W  = 2;
    parameter int unsigned IRQ_ADDR_W  = 16;
    parameter int unsigned IRQ_DATA_W  = 8;
    parameter logic [15:0] IRQ_BASE    = 16'h007C;
    parameter logic [15:0] IRQ_VEC_TOP = 16'hFFFA;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_ONE  = 2'd1;
    localparam lvl_t LVL_TWO  = 2'd2;
    localparam lvl_t LVL_NONE = 2'd3;

    typedef enum logic [1:0] {
        CODE_L1A = 2'b00,
        CODE_L1B = 2'b01,
        CODE_L2  = 2'b10,
        CODE_OFF = 2'b11
    } code_e;
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
    import irq_lvl_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_SRC_N,
    parameter int unsigned CODE_W  = IRQ_CODE_W,
    parameter int unsigned ADDR_W  = IRQ_ADDR_W,
    parameter int unsigned DATA_W  = IRQ_DATA_W,
    parameter logic [15:0] BASE    = IRQ_BASE,
    localparam int unsigned PER_REG = DATA_W / CODE_W,
    localparam int unsigned NUM_REG = (NUM_SRC + PER_REG - 1) / PER_REG,
    localparam int unsigned CODE_BITS = NUM_SRC * CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [CODE_BITS-1:0] codes
);
    logic [NUM_REG*DATA_W-1:0] flat;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic              hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(BASE + g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '1;
            else if (hit)
                q <= wr_data;
        end

        assign flat[g*DATA_W +: DATA_W] = q;
    end

    assign codes = flat[CODE_BITS-1:0];
endmodule

// File: rtl/irq_lvl_decode.sv
module irq_lvl_decode
    import irq_lvl_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_SRC_N,
    parameter int unsigned CODE_W  = IRQ_CODE_W
) (
    input  logic [NUM_SRC*CODE_W-1:0] codes,
    input  logic [NUM_SRC-1:0]        req,
    output logic [NUM_SRC-1:0]        active,
    output logic [NUM_SRC*2-1:0]      levels
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        code_e c;
        lvl_t  l;

        assign c = code_e'(codes[i*CODE_W +: 2]);

        always_comb begin
            unique case (c)
                CODE_L1A, CODE_L1B: l = LVL_ONE;
                CODE_L2:            l = LVL_TWO;
                default:            l = LVL_NONE;
            endcase
        end

        assign levels[i*2 +: 2] = l;
        assign active[i]        = req[i] && (l != LVL_NONE);
    end
endmodule

// File: rtl/irq_lvl_arbiter.sv
module irq_lvl_arbiter
    import irq_lvl_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_SRC_N,
    localparam int unsigned ID_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]   active,
    input  logic [NUM_SRC*2-1:0] levels,
    output logic                 win_vld,
    output logic [ID_W-1:0]      win_id,
    output lvl_t                 win_lvl
);
    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        win_lvl = LVL_NONE;
        // Scan downward so that an equal level at a lower number replaces the holder.
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i] && (!win_vld || levels[i*2 +: 2] <= win_lvl)) begin
                win_vld = 1'b1;
                win_id  = ID_W'(i);
                win_lvl = levels[i*2 +: 2];
            end
        end
    end
endmodule

// File: rtl/irq_lvl_vecgen.sv
module irq_lvl_vecgen
    import irq_lvl_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_SRC_N,
    parameter int unsigned ADDR_W  = IRQ_ADDR_W,
    parameter logic [15:0] VEC_TOP = IRQ_VEC_TOP,
    localparam int unsigned ID_W = $clog2(NUM_SRC)
) (
    input  logic [ID_W-1:0]   id,
    output logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] lo
);
    logic [ADDR_W-1:0] step;

    assign step = ADDR_W'({id, 1'b0});
    assign hi   = ADDR_W'(VEC_TOP) - step;
    assign lo   = hi + ADDR_W'(1);
endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_SRC_N,
    parameter int unsigned ADDR_W  = IRQ_ADDR_W,
    parameter int unsigned DATA_W  = IRQ_DATA_W,
    localparam int unsigned ID_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [1:0]         mask_lvl,
    output logic               irq_pend,
    output logic [1:0]         irq_lvl,
    output logic [ADDR_W-1:0]  vec_hi_addr,
    output logic [ADDR_W-1:0]  vec_lo_addr
);
    logic [NUM_SRC*IRQ_CODE_W-1:0] codes;
    logic [NUM_SRC-1:0]            req_q;
    logic [NUM_SRC-1:0]            active;
    logic [NUM_SRC*2-1:0]          levels;
    logic                          win_vld;
    logic [ID_W-1:0]               win_id;
    lvl_t                          win_lvl;
    logic [ADDR_W-1:0]             hi_c;
    logic [ADDR_W-1:0]             lo_c;

    irq_lvl_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .codes   (codes)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            req_q <= '0;
        else
            req_q <= irq_req;
    end

    irq_lvl_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .codes  (codes),
        .req    (req_q),
        .active (active),
        .levels (levels)
    );

    irq_lvl_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .active  (active),
        .levels  (levels),
        .win_vld (win_vld),
        .win_id  (win_id),
        .win_lvl (win_lvl)
    );

    irq_lvl_vecgen #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_vec (
        .id (win_id),
        .hi (hi_c),
        .lo (lo_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend    <= 1'b0;
            irq_lvl     <= LVL_NONE;
            vec_hi_addr <= '0;
            vec_lo_addr <= '0;
        end else if (win_vld) begin
            irq_pend    <= (win_lvl < mask_lvl);
            irq_lvl     <= win_lvl;
            vec_hi_addr <= hi_c;
            vec_lo_addr <= lo_c;
        end else begin
            irq_pend    <= 1'b0;
            irq_lvl     <= LVL_NONE;
            vec_hi_addr <= '0;
            vec_lo_addr <= '0;
        end
    end
endmodule

// File: rtl/irq_lvl_ctrl_chk.sv
module irq_lvl_ctrl_chk #(
    parameter int unsigned NUM_SRC = 12,
    parameter int unsigned ADDR_W  = 16,
    parameter logic [15:0] VEC_TOP = 16'hFFFA
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mask_lvl,
    input logic              irq_pend,
    input logic [1:0]        irq_lvl,
    input logic [ADDR_W-1:0] vec_hi_addr,
    input logic [ADDR_W-1:0] vec_lo_addr
);
    localparam logic [ADDR_W-1:0] VEC_LOW = ADDR_W'(VEC_TOP - 2 * (NUM_SRC - 1));

    AST_LVL_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lvl != 2'd0);                                                    // R3
    AST_PEND_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> (irq_lvl < $past(mask_lvl)));                           // R6
    AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != 2'd3) |-> (vec_lo_addr == vec_hi_addr + ADDR_W'(1)));    // R7
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != 2'd3) |-> (vec_hi_addr >= VEC_LOW && vec_hi_addr <= ADDR_W'(VEC_TOP)
                               && !vec_hi_addr[0]));                          // R7
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl == 2'd3) |-> (!irq_pend && vec_hi_addr == '0 && vec_lo_addr == '0)); // R10
endmodule

bind irq_lvl_ctrl irq_lvl_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_lvl    (mask_lvl),
    .irq_pend    (irq_pend),
    .irq_lvl     (irq_lvl),
    .vec_hi_addr (vec_hi_addr),
    .vec_lo_addr (vec_lo_addr)
);

// File: tb/tb_irq_lvl_ctrl.sv
`timescale 1ns/1ps
module tb_irq_lvl_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] irq_req = '0;
    logic [1:0]  mask_lvl = 2'd3;
    logic        irq_pend;
    logic [1:0]  irq_lvl;
    logic [15:0] vec_hi_addr;
    logic [15:0] vec_lo_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_lvl_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_req(irq_req), .mask_lvl(mask_lvl), .irq_pend(irq_pend), .irq_lvl(irq_lvl),
        .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] d);
        wr(16'h007C, d); wr(16'h007D, d); wr(16'h007E, d);
    endtask

    task automatic raise(input logic [11:0] r);
        @(negedge clk);
        irq_req = r;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input int lvl, input int pend, input int src);
        chk({req, " lvl"}, irq_lvl, lvl);
        chk({req, " pend"}, irq_pend, pend);
        if (src < 0) begin
            chk({req, " vhi"}, vec_hi_addr, 0);
            chk({req, " vlo"}, vec_lo_addr, 0);
        end else begin
            chk({req, " vhi"}, vec_hi_addr, 16'hFFFA - 2 * src);
            chk({req, " vlo"}, vec_lo_addr, 16'hFFFB - 2 * src);
        end
    endtask

    task automatic t_reset;
        raise(12'hFFF);
        expect_out("R1", 3, 0, -1);
        raise(12'h000);
    endtask

    task automatic t_layout;
        set_all(8'hFF);
        wr(16'h007C, 8'b11_10_11_11);    // source 2 at level 2 (bits 5:4)
        raise(12'h004); expect_out("R2 src2", 2, 1, 2);
        raise(12'h002); expect_out("R2 src1", 3, 0, -1);
        wr(16'h007E, 8'b00_11_11_11);    // source 11 at level 1 (bits 7:6)
        raise(12'h800); expect_out("R2 src11", 1, 1, 11);
        raise(12'h000);
    endtask

    task automatic t_decode;
        set_all(8'hFF);
        for (int c = 0; c < 4; c++) begin
            wr(16'h007D, 8'hF3 | 8'(c << 2));    // source 5 at bits 3:2
            raise(12'h020);
            if (c == 3) expect_out("R3 code11", 3, 0, -1);
            else        expect_out("R3 code", (c == 2) ? 2 : 1, 1, 5);
            raise(12'h000);
        end
    endtask

    task automatic t_priority;
        set_all(8'hFF);
        wr(16'h007C, 8'b11_10_11_11);    // src2 level 2
        wr(16'h007E, 8'b11_11_01_11);    // src9 level 1
        raise(12'h204); expect_out("R4", 1, 1, 9);
        raise(12'h000);
    endtask

    task automatic t_tie;
        set_all(8'hFF);
        wr(16'h007C, 8'b00_11_11_11);    // src3 code 00
        wr(16'h007D, 8'b01_10_11_11);    // src7 code 01, src6 level 2
        wr(16'h007E, 8'b11_10_11_11);    // src10 level 2
        raise(12'h088); expect_out("R5 l1", 1, 1, 3);
        raise(12'h440); expect_out("R5 l2", 2, 1, 6);
        raise(12'h000);
    endtask

    task automatic t_mask;
        set_all(8'hFF);
        wr(16'h007C, 8'b11_11_11_00);    // src0 level 1
        wr(16'h007D, 8'b11_11_11_10);    // src4 level 2
        mask_lvl = 2'd1;
        raise(12'h001); expect_out("R6 m1", 1, 0, 0);
        mask_lvl = 2'd2;
        @(posedge clk); @(negedge clk);
        chk("R6 m2", irq_pend, 1);
        raise(12'h010); expect_out("R6 l2m2", 2, 0, 4);
        mask_lvl = 2'd3;
        @(posedge clk); @(negedge clk);
        chk("R6 l2m3", irq_pend, 1);
        raise(12'h000);
    endtask

    task automatic t_vectors;
        set_all(8'h00);
        for (int n = 0; n < 12; n++) begin
            raise(12'(1 << n));
            expect_out("R7", 1, 1, n);
        end
        raise(12'h000);
    endtask

    task automatic t_outside;
        set_all(8'hFF);
        wr(16'h007B, 8'h00); wr(16'h007F, 8'h00); wr(16'h017C, 8'h00);
        raise(12'hFFF); expect_out("R8", 3, 0, -1);
        raise(12'h000);
    endtask

    task automatic t_latency;
        set_all(8'h00);
        raise(12'h000);
        expect_out("R10", 3, 0, -1);
        @(negedge clk); irq_req = 12'h100;
        @(posedge clk); @(negedge clk);
        chk("R9 one edge", irq_lvl, 3);
        @(posedge clk); @(negedge clk);
        chk("R9 two edges", irq_lvl, 1);
        chk("R9 vec", vec_hi_addr, 16'hFFFA - 16);
        raise(12'h000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_decode();
        t_priority();
        t_tie();
        t_mask();
        t_vectors();
        t_outside();
        t_latency();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule